// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one memory-to-memory copy channel for a larger chip. Software programs it through a small register window: a source pointer, a destination pointer, an item count, an interrupt index and a configuration word. The channel then moves items from source to destination over a simple request/grant memory master port, one read and one write per item. It can run free or be paced by one of several peripheral request lines. It can also restart on its own (circular reload), fill a region with a single value, or leave the bus idle for one cycle after each store so other masters can use it. An external freeze input halts it without loss of state.

The register window has eight word registers, selected by `reg_addr`:
- 0: source pointer.
- 1: destination pointer.
- 2: item count.
- 3: interrupt index.
- 4: configuration word.
- 5: run/status register. Writing bit 0 = 1 starts the channel and writing 0 stops it. Reading gives bit 0 = enabled, bit 1 = active and bit 2 = interrupt flag.
- 6: flag register. Writing bit 0 = 1 clears the interrupt flag.
- 7: progress counter, read only.

Reads are combinational. A memory access completes in the cycle where `mem_req` and `mem_gnt` are both high. Read data is taken from `mem_rdata` in that cycle. An item sits in the low bits of the data bus.

Top module: `copy_engine`

## Requirements
- R1: The configuration word holds these fields. Bits [2:1] give the item width: 0 = byte, 1 = halfword, 2 = word (3 acts as word). Bit 5 is the destination increment and bit 6 is the source increment. When an increment bit is set, that pointer advances by 1, 2 or 4 bytes after each item. When it is clear, the pointer stays fixed, and only `mem_size`-wide bytes are written.
- R2: In normal operation the channel stops after the programmed count. Active then clears, the enable bit clears and the progress counter equals the count.
- R3: In free-running mode (bit 4 clear), each item is one read grant followed by one write grant. Consecutive write requests are 3 cycles apart when bit 11 is clear. When bit 11 is set they are 4 cycles apart: one cycle with no request follows every store.
- R4: With bit 12 set (fill), the channel issues exactly one read per run and writes that value to every destination item.
- R5: With bit 4 set (paced), each rising edge moves exactly one item. The edge must come on the line chosen by configuration bits [16:13] while the channel waits between items. A held level gives no further items. Other lines, and select values with no line behind them (including 15), move nothing.
- R6: Bit 7 (circular) only acts in paced mode. After the last item the channel reloads both pointers, sets the progress counter to 0 and keeps running. In free-running mode the channel stops after the count, as in normal mode.
- R7: With bit 3 set, a sticky flag drives `irq`. The flag is set when the progress count reaches the interrupt index, or at the last item when the index is 0. Writing 1 to bit 0 of register 6 clears it. With bit 3 clear the flag never sets.
- R8: Writing 0 to register 5 mid-run stops the channel at once. No further memory requests are made, and the partial progress count stays readable.
- R9: While `freeze` is high, `mem_req` is low and the progress count holds. After release the run completes with correct data.
- R10: Starting with an item count of 0 is ignored: the channel stays disabled and makes no request.
- R11: After reset, `irq` and `mem_req` are low, and the status and progress registers read 0.
- R12: Register 4 reads back bits [16:0] as written, including the unused priority field in bits [10:8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Write data, item in low bits |
| mem_gnt | input | 1 | Grant; completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with grant on a read |
| trig_in | input | NUM_TRIG | Peripheral request lines |
| freeze | input | 1 | Halt progress while high |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with ADDR_W = 16, LEN_W = 8 and NUM_TRIG = 6. Because only six request lines exist, select values 6 to 14 also have no line behind them, so the no-trigger case is checked beyond the value 15. The narrow count keeps the counter compare small. Short item counts of 2 to 6 bring circular wrap, a mid-run stop and the interrupt index below the count within a few dozen cycles each.

// File: rtl/copy_engine_pkg.sv
// Shared types and helpers for the copy engine.
// Assumes a 32-bit register and data bus; widths of pointers and counts
// are set by the modules' parameters.
package copy_engine_pkg;

    localparam logic [2:0] RA_SRC  = 3'd0;
    localparam logic [2:0] RA_DST  = 3'd1;
    localparam logic [2:0] RA_LEN  = 3'd2;
    localparam logic [2:0] RA_IDX  = 3'd3;
    localparam logic [2:0] RA_CFG  = 3'd4;
    localparam logic [2:0] RA_RUN  = 3'd5;
    localparam logic [2:0] RA_FLAG = 3'd6;
    localparam logic [2:0] RA_CNT  = 3'd7;

    localparam int CFG_W = 17;

    // configuration word, msb first; bit positions are software visible
    typedef struct packed {
        logic [3:0] trig_sel;   // [16:13]
        logic       fill;       // [12]
        logic       yield;      // [11]
        logic [2:0] prio;       // [10:8]
        logic       circ;       // [7]
        logic       src_inc;    // [6]
        logic       dst_inc;    // [5]
        logic       paced;      // [4]
        logic       irq_en;     // [3]
        logic [1:0] width;      // [2:1]
        logic       spare;      // [0]
    } ctl_t;

    typedef enum logic [2:0] {
        ST_OFF, ST_WAIT, ST_RD, ST_WR, ST_GAP
    } seq_state_t;

    // byte step of one item
    function automatic logic [2:0] item_bytes(input logic [1:0] w);
        case (w)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // keep only the bytes of one item
    function automatic logic [31:0] item_mask(input logic [31:0] d, input logic [1:0] w);
        case (w)
            2'd0:    return {24'd0, d[7:0]};
            2'd1:    return {16'd0, d[15:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/copy_trig.sv
// Request-line edge detector.
// Registers every line each cycle and reports a rising edge on the selected
// line when the sequencer is ready to take one. Select values at or above
// NUM_TRIG have no line behind them. Assumes NUM_TRIG <= 15, so 15 is never a line.
module copy_trig #(
    parameter int NUM_TRIG = 15,
    parameter int SEL_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] lines,
    input  logic [SEL_W-1:0]    sel,
    input  logic                sample,
    output logic                fire
);
    logic [NUM_TRIG-1:0] prev_q;
    logic [NUM_TRIG-1:0] rise;

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_line
        // remember last level of line i
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lines[i];
        end
        assign rise[i] = lines[i] & ~prev_q[i];
    end

    // pick the selected line's edge
    always_comb begin
        fire = 1'b0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (sel == SEL_W'(i)) fire = rise[i] & sample;
        end
    end

    // R5: a level held high gives no second edge
    a_r5_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/copy_regs.sv
// Register window of the copy engine.
// Holds the configuration, the enable bit and the sticky interrupt flag,
// and produces start and stop pulses for the sequencer. Assumes software
// leaves the configuration alone while the channel is active.
module copy_regs
    import copy_engine_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic [LEN_W-1:0]  item_cnt,
    output logic [LEN_W-1:0]  irq_idx,
    output ctl_t              cfg,
    output logic              start,
    output logic              stop,
    output logic              irq,
    input  logic              active,
    input  logic              done,
    input  logic              irq_hit,
    input  logic [LEN_W-1:0]  progress
);
    logic [CFG_W-1:0] cfg_q;
    logic             en_q;
    logic             flag_q;
    logic             wr_run, wr_flag;

    assign wr_run  = reg_we && (reg_addr == RA_RUN);
    assign wr_flag = reg_we && (reg_addr == RA_FLAG);
    assign start   = wr_run && reg_wdata[0] && !en_q && !active && (item_cnt != '0);
    assign stop    = wr_run && !reg_wdata[0] && active;
    assign cfg     = ctl_t'(cfg_q);
    assign irq     = flag_q;

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_base <= '0;
            dst_base <= '0;
            item_cnt <= '0;
            irq_idx  <= '0;
            cfg_q    <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_SRC:  src_base <= reg_wdata[ADDR_W-1:0];
                RA_DST:  dst_base <= reg_wdata[ADDR_W-1:0];
                RA_LEN:  item_cnt <= reg_wdata[LEN_W-1:0];
                RA_IDX:  irq_idx  <= reg_wdata[LEN_W-1:0];
                RA_CFG:  cfg_q    <= reg_wdata[CFG_W-1:0];
                default: ;
            endcase
        end
    end

    // enable bit: set by a valid start, cleared by software or completion
    always_ff @(posedge clk) begin
        if (!rst_n)           en_q <= 1'b0;
        else if (start)       en_q <= 1'b1;
        else if (wr_run && !reg_wdata[0]) en_q <= 1'b0;
        else if (done)        en_q <= 1'b0;
    end

    // sticky interrupt flag; a new hit wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (irq_hit)                flag_q <= 1'b1;
        else if (wr_flag && reg_wdata[0]) flag_q <= 1'b0;
    end

    // read mux
    always_comb begin
        case (reg_addr)
            RA_SRC:  reg_rdata = 32'(src_base);
            RA_DST:  reg_rdata = 32'(dst_base);
            RA_LEN:  reg_rdata = 32'(item_cnt);
            RA_IDX:  reg_rdata = 32'(irq_idx);
            RA_CFG:  reg_rdata = 32'(cfg_q);
            RA_RUN:  reg_rdata = {29'd0, flag_q, active, en_q};
            RA_FLAG: reg_rdata = {31'd0, flag_q};
            default: reg_rdata = 32'(progress);
        endcase
    end

    // R7: the flag only drops through a clear write
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_flag && reg_wdata[0])) |=> flag_q);

    // R10: a start with zero items leaves the channel disabled
    a_r10_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_run && reg_wdata[0] && !en_q && (item_cnt == '0)) |=> !en_q);

endmodule

// File: rtl/copy_seq.sv
// Item sequencer of the copy engine.
// Walks the read/write steps of each item, advances the pointers and the
// progress counter, handles fill, circular reload, the post-store idle
// cycle, freeze and stop. Assumes the memory completes an access in the
// cycle its grant is seen with the request.
module copy_seq
    import copy_engine_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              freeze,
    input  ctl_t              cfg,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [LEN_W-1:0]  item_cnt,
    input  logic [LEN_W-1:0]  irq_idx,
    input  logic              trig_fire,
    output logic              trig_sample,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    output logic [LEN_W-1:0]  progress,
    output logic              active,
    output logic              done,
    output logic              irq_hit
);
    seq_state_t        st_q;
    logic [ADDR_W-1:0] a_q, b_q;
    logic [LEN_W-1:0]  cnt_q, cnt_n;
    logic [31:0]       data_q;
    logic              have_q;
    logic              acc, wr_acc, last, circ_eff, go;
    logic [1:0]        wsel;
    logic [ADDR_W-1:0] step;

    assign wsel      = (cfg.width == 2'd3) ? 2'd2 : cfg.width;
    assign step      = ADDR_W'(item_bytes(wsel));
    assign circ_eff  = cfg.circ && cfg.paced;
    assign mem_req   = ((st_q == ST_RD) || (st_q == ST_WR)) && !freeze && !stop;
    assign mem_we    = (st_q == ST_WR);
    assign mem_addr  = (st_q == ST_RD) ? a_q : b_q;
    assign mem_size  = wsel;
    assign mem_wdata = data_q;
    assign acc       = mem_req && mem_gnt;
    assign wr_acc    = acc && (st_q == ST_WR);
    assign cnt_n     = cnt_q + 1'b1;
    assign last      = (cnt_n == item_cnt);
    assign done      = wr_acc && last && !circ_eff;
    assign irq_hit   = wr_acc && cfg.irq_en &&
                       ((irq_idx == '0) ? last : (cnt_n == irq_idx));
    assign trig_sample = (st_q == ST_WAIT) && !freeze && !stop;
    assign go        = cfg.paced ? trig_fire : 1'b1;
    assign progress  = cnt_q;
    assign active    = (st_q != ST_OFF);

    // item state machine with pointer and counter updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            a_q    <= '0;
            b_q    <= '0;
            cnt_q  <= '0;
            data_q <= '0;
            have_q <= 1'b0;
        end else if (stop) begin
            st_q <= ST_OFF;
        end else if (start) begin
            st_q   <= ST_WAIT;
            a_q    <= src_base;
            b_q    <= dst_base;
            cnt_q  <= '0;
            have_q <= 1'b0;
        end else if (!freeze) begin
            case (st_q)
                ST_WAIT: if (go) st_q <= (cfg.fill && have_q) ? ST_WR : ST_RD;
                ST_RD: if (acc) begin
                    data_q <= item_mask(mem_rdata, wsel);
                    have_q <= 1'b1;
                    if (cfg.src_inc) a_q <= a_q + step;
                    st_q   <= ST_WR;
                end
                ST_WR: if (acc) begin
                    if (cfg.dst_inc) b_q <= b_q + step;
                    if (last && circ_eff) begin
                        a_q    <= src_base;
                        b_q    <= dst_base;
                        cnt_q  <= '0;
                        have_q <= 1'b0;
                        st_q   <= ST_WAIT;
                    end else if (last) begin
                        cnt_q <= cnt_n;
                        st_q  <= ST_OFF;
                    end else begin
                        cnt_q <= cnt_n;
                        st_q  <= (cfg.yield && !cfg.paced) ? ST_GAP : ST_WAIT;
                    end
                end
                ST_GAP:  st_q <= ST_WAIT;
                default: st_q <= ST_OFF;
            endcase
        end
    end

    // R9: no memory traffic while frozen
    a_r9_frozen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> !mem_req);

    // R4: once the fill value is held no read is issued
    a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.fill && have_q) |-> !(mem_req && !mem_we));

    // R3: a store in yield mode is followed by a cycle with no request
    a_r3_yield_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && cfg.yield && !cfg.paced && !last) |=> !mem_req);

    // R8: a stop ends memory traffic
    a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !mem_req);

    // R2: while running the counter stays below the item count
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < item_cnt));

    // R5: in paced mode nothing leaves the wait step without an edge
    a_r5_paced_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && cfg.paced && !trig_fire && !start) |=> (st_q != ST_RD && st_q != ST_WR));

endmodule

// File: rtl/copy_engine.sv
// Single-channel memory copy engine, top level.
// Ties the register window, the request-line edge detector and the item
// sequencer together. Assumes ADDR_W and LEN_W are at most 32 and
// NUM_TRIG is at most 15.
module copy_engine
    import copy_engine_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int NUM_TRIG = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [1:0]          mem_size,
    output logic [31:0]         mem_wdata,
    input  logic                mem_gnt,
    input  logic [31:0]         mem_rdata,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic                freeze,
    output logic                irq
);
    localparam int SEL_W = 4;

    ctl_t              cfg;
    logic [ADDR_W-1:0] src_base, dst_base;
    logic [LEN_W-1:0]  item_cnt, irq_idx, progress;
    logic              start, stop, active, done, irq_hit;
    logic              trig_fire, trig_sample;

    copy_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_base(src_base), .dst_base(dst_base), .item_cnt(item_cnt), .irq_idx(irq_idx),
        .cfg(cfg), .start(start), .stop(stop), .irq(irq),
        .active(active), .done(done), .irq_hit(irq_hit), .progress(progress)
    );

    copy_trig #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .lines(trig_in), .sel(cfg.trig_sel),
        .sample(trig_sample), .fire(trig_fire)
    );

    copy_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .freeze(freeze),
        .cfg(cfg), .src_base(src_base), .dst_base(dst_base),
        .item_cnt(item_cnt), .irq_idx(irq_idx),
        .trig_fire(trig_fire), .trig_sample(trig_sample),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .progress(progress), .active(active), .done(done), .irq_hit(irq_hit)
    );

endmodule

// File: tb/copy_engine_test.sv
// Directed bench for the copy engine: a byte memory model, one task per scenario.
module copy_engine_test;
    localparam int AW = 16;
    localparam int LW = 8;
    localparam int NT = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req, mem_we, mem_gnt;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [31:0]   mem_wdata, mem_rdata;
    logic [NT-1:0] trig_in = '0;
    logic          freeze = 1'b0;
    logic          irq;
    logic          stall = 1'b0;

    int checks = 0, fails = 0;
    int cyc = 0, rd_gnts = 0, wr_gnts = 0, last_wr = -1, wr_gap = 0;
    logic [7:0] mem [0:511];

    always #2 clk = ~clk;

    copy_engine #(.ADDR_W(AW), .LEN_W(LW), .NUM_TRIG(NT)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .trig_in(trig_in), .freeze(freeze), .irq(irq)
    );

    assign mem_gnt   = mem_req && !stall;
    assign mem_rdata = {mem[(mem_addr + 3) & 511], mem[(mem_addr + 2) & 511],
                        mem[(mem_addr + 1) & 511], mem[mem_addr & 511]};

    // memory write model
    always @(posedge clk) begin
        if (mem_req && mem_we && mem_gnt) begin
            mem[mem_addr & 511] <= mem_wdata[7:0];
            if (mem_size != 2'd0) mem[(mem_addr + 1) & 511] <= mem_wdata[15:8];
            if (mem_size == 2'd2) begin
                mem[(mem_addr + 2) & 511] <= mem_wdata[23:16];
                mem[(mem_addr + 3) & 511] <= mem_wdata[31:24];
            end
        end
    end

    // traffic monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_gnt && !mem_we) rd_gnts <= rd_gnts + 1;
        if (mem_req && mem_gnt && mem_we) begin
            wr_gnts <= wr_gnts + 1;
            if (last_wr >= 0) wr_gap <= cyc - last_wr;
            last_wr <= cyc;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cw(input int w, input bit ie, input bit pc, input bit di,
                                       input bit si, input bit ci, input int pr, input bit yl,
                                       input bit fl, input int ts);
        return (32'(w) << 1) | (32'(ie) << 3) | (32'(pc) << 4) | (32'(di) << 5) |
               (32'(si) << 6) | (32'(ci) << 7) | (32'(pr) << 8) | (32'(yl) << 11) |
               (32'(fl) << 12) | (32'(ts) << 13);
    endfunction

    function automatic logic [31:0] rdw(input int a);
        return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
    endfunction

    task automatic putw(input int a, input logic [31:0] v);
        {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]} = v;
    endtask

    task automatic setup(input int s, input int d, input int n, input int ix, input logic [31:0] c);
        wr_reg(3'd0, 32'(s)); wr_reg(3'd1, 32'(d)); wr_reg(3'd2, 32'(n));
        wr_reg(3'd3, 32'(ix)); wr_reg(3'd4, c);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            rd_reg(3'd5, s);
            if (s[1] == 1'b0) break;
        end
    endtask

    task automatic pulse(input int line);
        @(negedge clk); trig_in[line] = 1'b1;
        repeat (10) @(negedge clk);
        trig_in[line] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(3'd5, v); check("R11 status", v, 0);
        rd_reg(3'd7, v); check("R11 progress", v, 0);
        check("R11 irq", 32'(irq), 0);
        check("R11 mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_word_copy();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin putw(256 + 4*i, 32'h11223344 + 32'(i) * 32'h01010101); putw(384 + 4*i, 0); end
        setup(256, 384, 4, 0, cw(2, 1, 0, 1, 1, 0, 0, 0, 0, 15));
        wr_reg(3'd5, 1);
        wait_idle();
        for (int i = 0; i < 4; i++) check("R1 word copy", rdw(384 + 4*i), 32'h11223344 + 32'(i) * 32'h01010101);
        rd_reg(3'd7, v); check("R2 progress at end", v, 4);
        rd_reg(3'd5, v); check("R2 status at end", v, 32'h4);
        check("R7 irq at end with index 0", 32'(irq), 1);
        check("R3 back-to-back spacing", 32'(wr_gap), 3);
        wr_reg(3'd6, 1);
        check("R7 irq cleared", 32'(irq), 0);
    endtask

    task automatic t_narrow();
        mem[64] = 8'hAA; mem[65] = 8'hBB; mem[66] = 8'hCC;
        mem[96] = 8'h00; mem[97] = 8'h5A;
        setup(64, 96, 3, 0, cw(0, 0, 0, 0, 1, 0, 0, 0, 0, 15));
        wr_reg(3'd5, 1); wait_idle();
        check("R1 byte fixed dest gets last", 32'(mem[96]), 32'hCC);
        check("R1 byte dest neighbour untouched", 32'(mem[97]), 32'h5A);
        putw(32, 32'hBEEF1234); putw(48, 0); putw(52, 32'h77777777);
        setup(32, 48, 2, 0, cw(1, 0, 0, 1, 1, 0, 0, 0, 0, 15));
        wr_reg(3'd5, 1); wait_idle();
        check("R1 halfword step", rdw(48), 32'hBEEF1234);
        check("R1 halfword end", rdw(52), 32'h77777777);
    endtask

    task automatic t_yield();
        for (int i = 0; i < 3; i++) putw(128 + 4*i, 32'(i + 9));
        setup(128, 448, 3, 0, cw(2, 0, 0, 1, 1, 0, 0, 1, 0, 15));
        wr_reg(3'd5, 1); wait_idle();
        check("R3 yield spacing", 32'(wr_gap), 4);
        check("R3 yield data", rdw(456), 9 + 2);
    endtask

    task automatic t_fill();
        int r0;
        putw(16, 32'hCAFEF00D);
        for (int i = 0; i < 5; i++) putw(192 + 4*i, 0);
        r0 = rd_gnts;
        setup(16, 192, 5, 0, cw(2, 0, 0, 1, 1, 0, 0, 0, 1, 15));
        wr_reg(3'd5, 1); wait_idle();
        check("R4 single read", 32'(rd_gnts - r0), 1);
        for (int i = 0; i < 5; i++) check("R4 fill value", rdw(192 + 4*i), 32'hCAFEF00D);
    endtask

    task automatic t_paced();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) begin putw(224 + 4*i, 32'hA0 + 32'(i)); putw(320 + 4*i, 0); end
        setup(224, 320, 3, 0, cw(2, 0, 1, 1, 1, 0, 0, 0, 0, 2));
        wr_reg(3'd5, 1);
        repeat (5) @(negedge clk);
        rd_reg(3'd7, v); check("R5 no edge no item", v, 0);
        pulse(4);
        rd_reg(3'd7, v); check("R5 other line ignored", v, 0);
        pulse(2);
        rd_reg(3'd7, v); check("R5 one item per edge despite held level", v, 1);
        check("R5 first item data", rdw(320), 32'hA0);
        pulse(2); pulse(2);
        rd_reg(3'd5, v); check("R5 done after three edges", v, 0);
        check("R7 irq disabled stays low", 32'(irq), 0);
    endtask

    task automatic t_no_line();
        logic [31:0] v;
        setup(224, 320, 3, 0, cw(2, 0, 1, 1, 1, 0, 0, 0, 0, 15));
        wr_reg(3'd5, 1);
        for (int l = 0; l < NT; l++) pulse(l);
        rd_reg(3'd7, v); check("R5 select 15 moves nothing", v, 0);
        wr_reg(3'd5, 0);
        wr_reg(3'd4, cw(2, 0, 1, 1, 1, 0, 0, 0, 0, 7));
        wr_reg(3'd5, 1);
        for (int l = 0; l < NT; l++) pulse(l);
        rd_reg(3'd7, v); check("R5 select 7 moves nothing", v, 0);
        wr_reg(3'd5, 0);
    endtask

    task automatic t_irq_index();
        logic [31:0] v;
        setup(0, 256, 6, 3, cw(0, 1, 1, 1, 1, 0, 0, 0, 0, 0));
        wr_reg(3'd5, 1);
        pulse(0); pulse(0);
        check("R7 irq low before index", 32'(irq), 0);
        pulse(0);
        check("R7 irq at index", 32'(irq), 1);
        rd_reg(3'd6, v); check("R7 flag register", v, 1);
        wr_reg(3'd6, 1);
        pulse(0); pulse(0); pulse(0);
        rd_reg(3'd5, v); check("R7 no second irq at end", v, 0);
    endtask

    task automatic t_circular();
        logic [31:0] v;
        putw(160, 32'h0C0C0001); putw(164, 32'h0C0C0002);
        putw(288, 0); putw(292, 0);
        setup(160, 288, 2, 0, cw(2, 0, 1, 1, 1, 1, 0, 0, 0, 1));
        wr_reg(3'd5, 1);
        pulse(1); pulse(1);
        rd_reg(3'd7, v); check("R6 count reset on wrap", v, 0);
        rd_reg(3'd5, v); check("R6 still active after wrap", v[1], 1);
        putw(288, 0);
        pulse(1);
        check("R6 reload dest start", rdw(288), 32'h0C0C0001);
        rd_reg(3'd7, v); check("R6 count after wrap item", v, 1);
        wr_reg(3'd5, 0);
        setup(160, 288, 2, 0, cw(2, 0, 0, 1, 1, 1, 0, 0, 0, 15));
        wr_reg(3'd5, 1); wait_idle();
        rd_reg(3'd7, v); check("R6 circular ignored free-running", v, 2);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int w0;
        setup(0, 128, 4, 0, cw(2, 0, 1, 1, 1, 0, 0, 0, 0, 3));
        wr_reg(3'd5, 1);
        pulse(3); pulse(3);
        wr_reg(3'd5, 0);
        rd_reg(3'd5, v); check("R8 inactive after stop", v, 0);
        w0 = wr_gnts + rd_gnts;
        pulse(3);
        rd_reg(3'd7, v); check("R8 partial count kept", v, 2);
        check("R8 no traffic after stop", 32'(wr_gnts + rd_gnts - w0), 0);
    endtask

    task automatic t_freeze();
        logic [31:0] v, c0;
        int reqs = 0;
        for (int i = 0; i < 4; i++) begin putw(400 + 4*i, 32'hF0 + 32'(i)); putw(464 + 4*i, 0); end
        setup(400, 464, 4, 0, cw(2, 0, 0, 1, 1, 0, 0, 0, 0, 15));
        wr_reg(3'd5, 1);
        repeat (2) @(negedge clk);
        freeze = 1'b1;
        rd_reg(3'd7, c0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_req) reqs++;
        end
        rd_reg(3'd7, v);
        check("R9 count held", v, c0);
        check("R9 no request frozen", 32'(reqs), 0);
        freeze = 1'b0;
        wait_idle();
        check("R9 resume data", rdw(476), 32'hF3);
        rd_reg(3'd7, v); check("R9 resume count", v, 4);
    endtask

    task automatic t_len0_cfg();
        logic [31:0] v;
        int t0;
        setup(0, 0, 0, 0, cw(2, 0, 0, 1, 1, 0, 5, 0, 0, 15));
        t0 = rd_gnts + wr_gnts;
        wr_reg(3'd5, 1);
        repeat (4) @(negedge clk);
        rd_reg(3'd5, v); check("R10 zero count ignored", v, 0);
        check("R10 no traffic", 32'(rd_gnts + wr_gnts - t0), 0);
        wr_reg(3'd4, 32'h1ABCD);
        rd_reg(3'd4, v); check("R12 config readback", v, 32'h1ABCD);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_copy();
        t_narrow();
        t_yield();
        t_fill();
        t_paced();
        t_no_line();
        t_irq_index();
        t_circular();
        t_stop();
        t_freeze();
        t_len0_cfg();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        wait (cyc >= 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected run end", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule